// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings a single-data-rate SDRAM out of power-up and then keeps it refreshed. After reset it holds the memory idle for a stabilization time. It then closes every bank, runs a configurable number of auto-refresh cycles and programs the mode register. Only then does it report that the memory is usable. From that point on it raises a refresh request at a fixed spacing. The main command engine takes each request with an acknowledge pulse.

All delays are given in nanoseconds, together with the clock period in picoseconds. They are turned into cycle counts at elaboration time. The refresh spacing is rounded down to whole cycles, so the memory is never refreshed late. Every other delay is rounded up, so no minimum is ever violated. Each result is at least one cycle.

The sequencer only produces command requests, a mode word, a constant clock enable and a ready flag. Pin drive, data and the host side belong to the command engine.

Top module: `sdr_init_refresh`

Cycle counts used below:
- PU = ceil(PWRUP_NS·1000 / CLK_PERIOD_PS)
- RP = ceil(TRP_NS·1000 / CLK_PERIOD_PS)
- RFC = ceil(TRFC_NS·1000 / CLK_PERIOD_PS)
- REFI = floor(REFRESH_NS·1000 / CLK_PERIOD_PS)

Each count has a minimum of 1. An edge index counts the rising clock edges after reset is released, and the first such edge has index 0. A command is issued at edge e when `cmd_valid` is high just before that edge.

## Requirements
- R1: While `rst_n` is low, `cmd_valid`, `ready` and `ref_req` are all low.
- R2: No command is issued before edge PU. The first command is PRECHARGE ALL (`cmd_code` 1), issued exactly at edge PU.
- R3: The first AUTO REFRESH (`cmd_code` 2) is issued exactly RP edges after the precharge.
- R4: Exactly INIT_REFRESHES auto-refresh commands are issued during initialization, each exactly RFC edges after the one before.
- R5: LOAD MODE (`cmd_code` 3) is issued exactly RFC edges after the last initialization refresh. Its mode word carries:
  - the CAS latency in bits 6:4;
  - 0 in bit 3 (sequential bursts);
  - 0 in bits 2:0 (burst length 1);
  - 0 in all other bits.
- R6: `ready` first goes high exactly TMRD_CYC edges after LOAD MODE and then stays high until reset.
- R7: No command request is issued while `ready` is high.
- R8: `cke` is high at all times.
- R9: `ref_req` stays low until `ready` is high. It first goes high exactly REFI edges after the edge at which `ready` first appeared.
- R10: Once high, `ref_req` stays high until the edge at which `ref_ack` is sampled high.
- R11: An acknowledge taken at edge a clears `ref_req` after that edge. The next request appears exactly at edge a+REFI.
- R12: `ref_ack` sampled while `ref_req` is low has no effect: the request stays low and the next request keeps its original edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | Command engine has taken the pending refresh |
| cmd_valid | output | 1 | An initialization command is issued this cycle |
| cmd_code | output | 2 | 1 precharge all, 2 auto refresh, 3 load mode |
| mode_word | output | MODE_W | Mode register value, valid with LOAD MODE |
| cke | output | 1 | SDRAM clock enable, tied high |
| ready | output | 1 | Initialization complete |
| ref_req | output | 1 | Refresh is due, held until acknowledged |

## Verification
The bench runs a small configuration in which the tRP target is not a whole number of cycles, so rounding up must add a cycle. The refresh target is also not whole, so rounding down must drop a fraction. A design that rounds the wrong way moves a command or a request by one edge, and the exact edge checks catch it.

The bench then sweeps the acknowledge delay from zero to five cycles. A design that restarts the interval when the request is raised, rather than when it is acknowledged, puts the next request early by the wait. A design that drops the request before acknowledge would lose a refresh.

A stray acknowledge is sent while no request is pending. A design that honours it would shift the following request or briefly clear a request that is not there.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    SDR_NONE          = 2'd0,
    SDR_PRECHARGE_ALL = 2'd1,
    SDR_AUTO_REFRESH  = 2'd2,
    SDR_LOAD_MODE     = 2'd3
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    INIT_PRE = 3'd0,
    INIT_REF = 3'd1,
    INIT_LMR = 3'd2,
    INIT_MRD = 3'd3,
    INIT_RUN = 3'd4
  } sdr_init_state_e;

  // Delay rounded up to whole cycles, never below one cycle.
  function automatic int unsigned cycles_at_least(input int unsigned ns, input int unsigned clk_ps);
    logic [63:0] ps;
    logic [63:0] c;
    ps = 64'(ns) * 64'd1000;
    c  = (ps + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    if (c < 64'd1) c = 64'd1;
    return int'(c[31:0]);
  endfunction

  // Interval rounded down to whole cycles, never below one cycle.
  function automatic int unsigned cycles_at_most(input int unsigned ns, input int unsigned clk_ps);
    logic [63:0] ps;
    logic [63:0] c;
    ps = 64'(ns) * 64'd1000;
    c  = ps / 64'(clk_ps);
    if (c < 64'd1) c = 64'd1;
    return int'(c[31:0]);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sdr_cycle_timer.sv
module sdr_cycle_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_seq_pkg::*;
#(
  parameter int unsigned PU_CYC  = 5000,
  parameter int unsigned RP_CYC  = 1,
  parameter int unsigned RFC_CYC = 4,
  parameter int unsigned MRD_CYC = 2,
  parameter int unsigned NREF    = 2,
  parameter int unsigned W       = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       cmd_valid,
  output logic [1:0] cmd_code,
  output logic       ready,
  output logic       run_start
);

  localparam int unsigned CNT_W = bits_for(NREF);

  sdr_init_state_e state, state_nxt;
  sdr_cmd_e        cmd;
  logic            tmr_load;
  logic [W-1:0]    tmr_val;
  logic            tmr_expired;
  logic [CNT_W-1:0] ref_cnt;
  logic            ref_issued;

  sdr_cycle_timer #(.W(W), .RST_VAL(PU_CYC)) u_step_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_nxt = state;
    cmd       = SDR_NONE;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      INIT_PRE: if (tmr_expired) begin
        cmd       = SDR_PRECHARGE_ALL;
        tmr_load  = 1'b1;
        tmr_val   = W'(RP_CYC - 1);
        state_nxt = INIT_REF;
      end
      INIT_REF: if (tmr_expired) begin
        cmd      = SDR_AUTO_REFRESH;
        tmr_load = 1'b1;
        tmr_val  = W'(RFC_CYC - 1);
        if (ref_cnt == CNT_W'(NREF - 1)) state_nxt = INIT_LMR;
      end
      INIT_LMR: if (tmr_expired) begin
        cmd       = SDR_LOAD_MODE;
        tmr_load  = 1'b1;
        tmr_val   = W'(MRD_CYC - 1);
        state_nxt = INIT_MRD;
      end
      INIT_MRD: if (tmr_expired) state_nxt = INIT_RUN;
      default: ;
    endcase
  end

  assign ref_issued = (cmd == SDR_AUTO_REFRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= INIT_PRE;
      ref_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (ref_issued) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assign cmd_valid = (cmd != SDR_NONE);
  assign cmd_code  = cmd;
  assign run_start = (state == INIT_MRD) && tmr_expired;
  assign ready     = (state == INIT_RUN) || run_start;

  AST_ALL_INIT_REFRESHES: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_code == SDR_LOAD_MODE) |-> (ref_cnt == CNT_W'(NREF))); // R4
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready); // R6
  AST_QUIET_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) ready |-> !cmd_valid); // R7

endmodule

// File: rtl/sdr_refresh_ctl.sv
module sdr_refresh_ctl #(
  parameter int unsigned REFI_CYC = 781,
  parameter int unsigned W        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ref_ack,
  output logic ref_req
);

  logic running;
  logic take;
  logic interval_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  assign take = ref_req && ref_ack;

  sdr_cycle_timer #(.W(W), .RST_VAL(0)) u_interval_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start || take),
    .load_val (W'(REFI_CYC - 1)),
    .expired  (interval_done)
  );

  assign ref_req = running && interval_done;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (ref_req && !ref_ack) |=> ref_req); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (REFI_CYC > 1 && ref_req && ref_ack) |=> !ref_req); // R11

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 20000,
  parameter int unsigned PWRUP_NS       = 100000,
  parameter int unsigned REFRESH_NS     = 15625,
  parameter int unsigned TRFC_NS        = 70,
  parameter int unsigned TRP_NS         = 20,
  parameter int unsigned TMRD_CYC       = 2,
  parameter int unsigned INIT_REFRESHES = 2,
  parameter int unsigned CAS_LATENCY    = 3,
  parameter int unsigned MODE_W         = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_ack,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [MODE_W-1:0] mode_word,
  output logic              cke,
  output logic              ready,
  output logic              ref_req
);

  localparam int unsigned PU_CYC   = cycles_at_least(PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC   = cycles_at_least(TRP_NS, CLK_PERIOD_PS);
  localparam int unsigned RFC_CYC  = cycles_at_least(TRFC_NS, CLK_PERIOD_PS);
  localparam int unsigned MRD_CYC  = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
  localparam int unsigned REFI_CYC = cycles_at_most(REFRESH_NS, CLK_PERIOD_PS);
  localparam int unsigned INIT_W   = bits_for(max4(PU_CYC, RP_CYC, RFC_CYC, MRD_CYC));
  localparam int unsigned REFI_W   = bits_for(REFI_CYC);

  logic run_start;

  sdr_init_fsm #(
    .PU_CYC  (PU_CYC),
    .RP_CYC  (RP_CYC),
    .RFC_CYC (RFC_CYC),
    .MRD_CYC (MRD_CYC),
    .NREF    (INIT_REFRESHES),
    .W       (INIT_W)
  ) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .ready     (ready),
    .run_start (run_start)
  );

  sdr_refresh_ctl #(
    .REFI_CYC (REFI_CYC),
    .W        (REFI_W)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (run_start),
    .ref_ack (ref_ack),
    .ref_req (ref_req)
  );

  // CAS latency in bits 6:4, sequential bursts of one word.
  assign mode_word = MODE_W'(CAS_LATENCY << 4);
  assign cke       = 1'b1;

  AST_NO_REQ_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !ref_req); // R9

endmodule

// File: tb/test_sdr_init_refresh.sv
module test_sdr_init_refresh;

  localparam int unsigned CLK_PS = 20000;
  localparam int unsigned PWRUP  = 1000;
  localparam int unsigned RPNS   = 50;
  localparam int unsigned RFCNS  = 70;
  localparam int unsigned REFINS = 1990;
  localparam int unsigned NREF   = 3;
  localparam int unsigned CAS    = 2;
  localparam int unsigned MRD    = 2;
  localparam int unsigned MW     = 12;

  localparam int PU   = (PWRUP * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RP   = (RPNS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RFC  = (RFCNS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int REFI = (REFINS * 1000) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ack = 1'b0;
  logic cmd_valid, cke, ready, ref_req;
  logic [1:0] cmd_code;
  logic [MW-1:0] mode_word;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit cke_bad = 0;
  bit late_cmd = 0;
  int ev_cyc[16];
  int ev_code[16];
  int nev = 0;
  int ready_at = -1;

  sdr_init_refresh #(
    .CLK_PERIOD_PS(CLK_PS), .PWRUP_NS(PWRUP), .REFRESH_NS(REFINS), .TRFC_NS(RFCNS),
    .TRP_NS(RPNS), .TMRD_CYC(MRD), .INIT_REFRESHES(NREF), .CAS_LATENCY(CAS), .MODE_W(MW)
  ) i_sdr_init_refresh (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .mode_word(mode_word), .cke(cke), .ready(ready), .ref_req(ref_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cke !== 1'b1) cke_bad = 1;
    if (rst_n && ready && cmd_valid) late_cmd = 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int a;
    int lmr_at;
    // R1 / R8: state while reset is held
    repeat (3) step();
    chk(cmd_valid == 1'b0 && ready == 1'b0 && ref_req == 1'b0, "R1 reset outputs",
        {cmd_valid, ready, ref_req}, 0);
    chk(cke == 1'b1, "R8 cke in reset", cke, 1);
    rst_n = 1'b1;
    cyc = 0;

    // initialization: record every command edge
    while (!ready && cyc < 2000) begin
      step();
      if (cmd_valid && nev < 16) begin
        ev_cyc[nev]  = cyc;
        ev_code[nev] = int'(cmd_code);
        nev++;
      end
      if (ready) ready_at = cyc;
    end

    chk(nev == NREF + 2, "R4 init command count", nev, NREF + 2);
    if (nev == NREF + 2) begin
      chk(ev_cyc[0] == PU && ev_code[0] == 1, "R2 precharge edge", ev_cyc[0], PU);
      chk(ev_code[1] == 2 && ev_cyc[1] - ev_cyc[0] == RP, "R3 precharge to refresh",
          ev_cyc[1] - ev_cyc[0], RP);
      for (int i = 2; i <= NREF; i++)
        chk(ev_code[i] == 2 && ev_cyc[i] - ev_cyc[i-1] == RFC, "R4 refresh spacing",
            ev_cyc[i] - ev_cyc[i-1], RFC);
      lmr_at = ev_cyc[NREF+1];
      chk(ev_code[NREF+1] == 3 && lmr_at - ev_cyc[NREF] == RFC, "R5 load mode spacing",
          lmr_at - ev_cyc[NREF], RFC);
      chk(ready_at == lmr_at + MRD, "R6 ready edge", ready_at, lmr_at + MRD);
    end
    chk(mode_word == MW'(CAS * 16), "R5 mode word", int'(mode_word), CAS * 16);

    // first refresh request
    while (!ref_req && cyc < 4000) step();
    chk(cyc == ready_at + REFI, "R9 first request edge", cyc, ready_at + REFI);

    // sweep acknowledge delay
    for (int d = 0; d <= 5; d++) begin
      for (int k = 0; k < d; k++) begin
        step();
        chk(ref_req == 1'b1, "R10 request held", ref_req, 1);
      end
      a = cyc;
      ref_ack = 1'b1;
      step();
      ref_ack = 1'b0;
      chk(ref_req == 1'b0, "R11 request cleared", ref_req, 0);
      if (d == 2) begin
        repeat (9) step();
        ref_ack = 1'b1;
        step();
        ref_ack = 1'b0;
        chk(ref_req == 1'b0, "R12 stray ack", ref_req, 0);
      end
      while (!ref_req && cyc < a + 3 * REFI) step();
      if (d == 2) chk(cyc == a + REFI, "R12 interval kept", cyc - a, REFI);
      else        chk(cyc == a + REFI, "R11 interval from ack", cyc - a, REFI);
    end

    chk(ready == 1'b1, "R6 ready kept", ready, 1);
    chk(late_cmd == 1'b0, "R7 no command after ready", late_cmd, 0);
    chk(cke_bad == 1'b0, "R8 cke always high", cke_bad, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule